// File: doc/BRIEF.md
# SD Card SPI-Mode Block Data Phase Engine

This engine runs the data phase of an SD card transaction in SPI mode. It starts once a read or write command has already been accepted by the card and chip select is still held low by the surrounding logic. It moves whole blocks one byte transfer at a time through a byte-exchange port to an external SPI shifter. It never issues commands, never drives chip select, and never computes a CRC.

For reads, it clocks fill bytes until the card's start token appears. It then passes every data byte of the block onto a ready/valid output stream and latches the two trailing CRC bytes for an external checker. For writes, it sends the start token, the data bytes taken from a ready/valid input stream, and two CRC placeholder bytes. It then classifies the card's data response token and polls until the card stops signalling busy. Multi-block writes use their own start token and end with a stop token. A rejected block ends the write early. The engine ends every run with a one-cycle done pulse, a status code and the index of the block that failed.

Top module: `sd_data_phase`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `spi_go`, `rd_valid` and `wr_ready` are 0, `status` is 0 and `crc_word` is 0.
- R2: In a read, every byte transfer before the start token sends 0xFF, and any received byte other than 0xFE is skipped. Once 0xFE is seen, the next `BLOCK_BYTES` received bytes appear in order on `rd_data`. While `rd_valid` is high and `rd_ready` is low, the byte on `rd_data` is held stable.
- R3: After the data bytes of each read block, two more bytes are received and stored in `crc_word`, the first in bits 15:8 and the second in bits 7:0.
- R4: If `TOKEN_POLLS` polls in a row return something other than 0xFE, the run ends with `status` = 1 (read timeout) and `fail_block` = that block's index, and no further byte is exchanged.
- R5: With `block_count` > 1 on a read, each block separately searches for its own 0xFE token, with a fresh poll budget.
- R6: A write sends one start token per block: 0xFE when `block_count` is 1, and 0xFC for every block when it is greater than 1. The token is followed by `BLOCK_BYTES` bytes taken in order from the `wr_data` stream, then 0xFF, 0xFF.
- R7: After the CRC bytes, one 0xFF poll returns the response token. The block is accepted only if the received byte ANDed with 0x1F equals 0x05. Any other value gives `status` = 2 (write rejected) and `fail_block` = that block, and no later block is sent.
- R8: After each response token, 0xFF polls continue until the card returns 0xFF. If `BUSY_POLLS` polls in a row return something else, the run ends at once with `status` = 3 (busy timeout) and `fail_block` = the current block, and no stop token is sent.
- R9: A write with `block_count` > 1 sends the stop token 0xFD after its last accepted block, or after a rejected block, and then polls busy again before finishing.
- R10: `start` with `block_count` = 0 gives `done` with `status` = 0 in the next cycle, with no byte transfer.
- R11: `start` while `busy` is high is ignored and does not change the run in progress.
- R12: `done` is a one-cycle pulse with `busy` low in the same cycle. `status` changes only in a cycle where `done` is high, and holds its value until the next run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a data phase (taken only when idle) |
| write_mode | input | 1 | 1 = write, 0 = read, sampled with start |
| block_count | input | CNT_W | Number of blocks, sampled with start |
| spi_go | output | 1 | One-cycle request for one byte exchange |
| spi_tx | output | 8 | Byte to send, valid with spi_go |
| spi_fin | input | 1 | One-cycle pulse marking the exchange complete |
| spi_rx | input | 8 | Byte received, valid with spi_fin |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Consumer takes rd_data |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | wr_data holds a byte |
| wr_ready | output | 1 | Engine takes wr_data |
| crc_word | output | 16 | CRC bytes of the last read block |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished (one cycle) |
| status | output | 2 | 0 ok, 1 read timeout, 2 write rejected, 3 busy timeout |
| fail_block | output | CNT_W | Index of the block where the run stopped |

## Verification
The reads use token leads of zero polls, of one poll short of the budget, and of exactly the budget. Mixing 0x7F and 0xFF in the lead shows that only 0xFE starts a block. The same leads show where timeout and acceptance part. The writes cover single and multi-block runs, response bytes with junk in the upper bits (0xE5, 0xED) and clean codes (0x0B), and busy lengths of zero, budget minus one and the full budget. Together these show token choice, masking, early abort and whether a stop token follows. The full byte log of every run is compared with a sequence worked out from the requirements. Stalls on both streams and a start pulse in the middle of a run show that flow control and busy-time starts do not change the bytes exchanged.

// File: rtl/sddp_pkg.sv
// Shared types and token values for the SD data phase engine.
// Assumes SPI-mode single/multi block framing with CRC checking left outside.
package sddp_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_R_HUNT, ST_R_DATA, ST_R_CRC,
        ST_W_TOKEN, ST_W_DATA, ST_W_CRC, ST_W_RESP, ST_W_BUSY, ST_W_STOP
    } eng_state_t;

    typedef enum logic [1:0] {
        XS_OK           = 2'd0,
        XS_RD_TIMEOUT   = 2'd1,
        XS_WR_REJECT    = 2'd2,
        XS_BUSY_TIMEOUT = 2'd3
    } xfer_status_t;

    localparam logic [7:0] TOK_SINGLE = 8'hFE;
    localparam logic [7:0] TOK_MULTI  = 8'hFC;
    localparam logic [7:0] TOK_STOP   = 8'hFD;
    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] RESP_MASK  = 8'h1F;
    localparam logic [7:0] RESP_OK    = 8'h05;
endpackage

// File: rtl/sddp_poll_ctr.sv
// Bounded poll counter: counts failed polls and flags the one that exhausts
// the budget. Assumes LIMIT >= 1; clr has priority over step.
module sddp_poll_ctr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt;

    // count failed polls since the last clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (step)     cnt <= cnt + 1'b1;
    end

    // the current poll is the final allowed one
    assign last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/sddp_resp_check.sv
// Data response token classifier: accepted when the low five bits carry
// the acceptance code. Assumes the upper three bits are undefined.
module sddp_resp_check
    import sddp_pkg::*;
(
    input  logic [7:0] resp,
    output logic       accepted
);
    // compare masked token against the acceptance code
    always_comb accepted = ((resp & RESP_MASK) == RESP_OK);
endmodule

// File: rtl/sddp_rd_hold.sv
// One-entry output register for the read stream. Assumes load only occurs
// while empty or being drained (the engine issues reads only when empty).
module sddp_rd_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       ready,
    output logic       valid,
    output logic [7:0] dout
);
    // hold a byte until the consumer accepts it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= 8'h00;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sd_data_phase.sv
// SD SPI-mode data phase engine. Reads: hunt start token, stream block bytes,
// latch CRC. Writes: token, data, CRC filler, response check, busy poll,
// stop token for multi-block. Assumes command issue and chip select are
// handled outside and that at most one byte exchange is outstanding.
module sd_data_phase
    import sddp_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int CNT_W       = 8,
    parameter int TOKEN_POLLS = 4096,
    parameter int BUSY_POLLS  = 65535
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             write_mode,
    input  logic [CNT_W-1:0] block_count,
    output logic             spi_go,
    output logic [7:0]       spi_tx,
    input  logic             spi_fin,
    input  logic [7:0]       spi_rx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [15:0]      crc_word,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic [CNT_W-1:0] fail_block
);
    localparam int BYTE_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
    localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(BLOCK_BYTES - 1);

    eng_state_t       st;
    logic             pend;
    logic [BYTE_W-1:0] bcnt;
    logic             half;
    logic [CNT_W-1:0] blk, nblk;
    logic             multi, rejected, ending;
    logic             want_go;
    logic [7:0]       tx_next;
    logic             fin_now, last_blk, resp_ok;
    logic             hunt_clr, hunt_step, hunt_last;
    logic             bsy_clr, bsy_step, bsy_last;
    logic             rd_load;

    assign fin_now  = spi_fin && pend;
    assign last_blk = (blk == nblk - 1'b1);
    assign busy     = (st != ST_IDLE);
    assign wr_ready = (st == ST_W_DATA) && !pend;
    assign rd_load  = fin_now && (st == ST_R_DATA);

    assign hunt_clr  = (st != ST_R_HUNT);
    assign hunt_step = fin_now && (st == ST_R_HUNT) && (spi_rx != TOK_SINGLE) && !hunt_last;
    assign bsy_clr   = (st != ST_W_BUSY);
    assign bsy_step  = fin_now && (st == ST_W_BUSY) && (spi_rx != FILL_BYTE) && !bsy_last;

    sddp_poll_ctr #(.LIMIT(TOKEN_POLLS)) u_hunt (
        .clk(clk), .rst_n(rst_n), .clr(hunt_clr), .step(hunt_step), .last(hunt_last));

    sddp_poll_ctr #(.LIMIT(BUSY_POLLS)) u_bsy (
        .clk(clk), .rst_n(rst_n), .clr(bsy_clr), .step(bsy_step), .last(bsy_last));

    sddp_resp_check u_resp (.resp(spi_rx), .accepted(resp_ok));

    sddp_rd_hold u_hold (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .din(spi_rx),
        .ready(rd_ready), .valid(rd_valid), .dout(rd_data));

    // decide whether to launch a byte exchange this cycle and with which byte
    always_comb begin
        want_go = 1'b0;
        tx_next = FILL_BYTE;
        case (st)
            ST_R_HUNT, ST_R_CRC, ST_W_CRC, ST_W_RESP, ST_W_BUSY: want_go = !pend;
            ST_R_DATA:  want_go = !pend && !rd_valid;
            ST_W_TOKEN: begin
                want_go = !pend;
                tx_next = multi ? TOK_MULTI : TOK_SINGLE;
            end
            ST_W_DATA: begin
                want_go = !pend && wr_valid;
                tx_next = wr_data;
            end
            ST_W_STOP: begin
                want_go = !pend;
                tx_next = TOK_STOP;
            end
            default: want_go = 1'b0;
        endcase
    end

    // sequence the data phase and record the outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            pend       <= 1'b0;
            spi_go     <= 1'b0;
            spi_tx     <= FILL_BYTE;
            bcnt       <= '0;
            half       <= 1'b0;
            blk        <= '0;
            nblk       <= '0;
            multi      <= 1'b0;
            rejected   <= 1'b0;
            ending     <= 1'b0;
            crc_word   <= 16'h0000;
            done       <= 1'b0;
            status     <= XS_OK;
            fail_block <= '0;
        end else begin
            spi_go <= 1'b0;
            done   <= 1'b0;
            if (want_go) begin
                spi_go <= 1'b1;
                spi_tx <= tx_next;
                pend   <= 1'b1;
            end else if (fin_now) begin
                pend <= 1'b0;
            end

            case (st)
                ST_IDLE: if (start) begin
                    blk      <= '0;
                    nblk     <= block_count;
                    multi    <= (block_count > CNT_W'(1));
                    rejected <= 1'b0;
                    ending   <= 1'b0;
                    bcnt     <= '0;
                    half     <= 1'b0;
                    if (block_count == '0) begin
                        done       <= 1'b1;
                        status     <= XS_OK;
                        fail_block <= '0;
                    end else begin
                        st <= write_mode ? ST_W_TOKEN : ST_R_HUNT;
                    end
                end
                ST_R_HUNT: if (fin_now) begin
                    if (spi_rx == TOK_SINGLE) begin
                        st   <= ST_R_DATA;
                        bcnt <= '0;
                    end else if (hunt_last) begin
                        st         <= ST_IDLE;
                        done       <= 1'b1;
                        status     <= XS_RD_TIMEOUT;
                        fail_block <= blk;
                    end
                end
                ST_R_DATA: if (fin_now) begin
                    if (bcnt == BYTE_LAST) begin
                        st   <= ST_R_CRC;
                        half <= 1'b0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_R_CRC: if (fin_now) begin
                    if (!half) begin
                        crc_word[15:8] <= spi_rx;
                        half           <= 1'b1;
                    end else begin
                        crc_word[7:0] <= spi_rx;
                        if (last_blk) begin
                            st         <= ST_IDLE;
                            done       <= 1'b1;
                            status     <= XS_OK;
                            fail_block <= blk;
                        end else begin
                            blk <= blk + 1'b1;
                            st  <= ST_R_HUNT;
                        end
                    end
                end
                ST_W_TOKEN: if (fin_now) begin
                    st   <= ST_W_DATA;
                    bcnt <= '0;
                end
                ST_W_DATA: if (fin_now) begin
                    if (bcnt == BYTE_LAST) begin
                        st   <= ST_W_CRC;
                        half <= 1'b0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_W_CRC: if (fin_now) begin
                    if (!half) half <= 1'b1;
                    else       st   <= ST_W_RESP;
                end
                ST_W_RESP: if (fin_now) begin
                    rejected <= !resp_ok;
                    st       <= ST_W_BUSY;
                end
                ST_W_BUSY: if (fin_now) begin
                    if (spi_rx == FILL_BYTE) begin
                        if (ending || ((rejected || last_blk) && !multi)) begin
                            st         <= ST_IDLE;
                            done       <= 1'b1;
                            status     <= rejected ? XS_WR_REJECT : XS_OK;
                            fail_block <= blk;
                        end else if (rejected || last_blk) begin
                            st <= ST_W_STOP;
                        end else begin
                            blk <= blk + 1'b1;
                            st  <= ST_W_TOKEN;
                        end
                    end else if (bsy_last) begin
                        st         <= ST_IDLE;
                        done       <= 1'b1;
                        status     <= XS_BUSY_TIMEOUT;
                        fail_block <= blk;
                    end
                end
                ST_W_STOP: if (fin_now) begin
                    ending <= 1'b1;
                    st     <= ST_W_BUSY;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sddp_checker.sv
// Protocol checker for sd_data_phase, attached by bind below.
// Assumes the synchronous active-low reset of the engine.
module sddp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       spi_go,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R12

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> done); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_go && !wr_ready); // R10
endmodule

bind sd_data_phase sddp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .status(status),
    .spi_go(spi_go), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data));

// File: tb/sim_sd_data_phase.sv
// Bench: small configuration, card model answering every byte exchange.
module sim_sd_data_phase;
    localparam int B  = 4;
    localparam int CW = 4;
    localparam int TP = 4;
    localparam int BP = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0, start = 1'b0, write_mode = 1'b0;
    logic [CW-1:0] block_count = '0;
    logic          spi_go, spi_fin = 1'b0;
    logic [7:0]    spi_tx, spi_rx = 8'hFF;
    logic [7:0]    rd_data, wr_data = 8'h00;
    logic          rd_valid, rd_ready = 1'b0, wr_valid = 1'b0, wr_ready;
    logic [15:0]   crc_word;
    logic          busy, done;
    logic [1:0]    status;
    logic [CW-1:0] fail_block;

    sd_data_phase #(.BLOCK_BYTES(B), .CNT_W(CW), .TOKEN_POLLS(TP), .BUSY_POLLS(BP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
        .block_count(block_count), .spi_go(spi_go), .spi_tx(spi_tx),
        .spi_fin(spi_fin), .spi_rx(spi_rx), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .crc_word(crc_word), .busy(busy), .done(done), .status(status),
        .fail_block(fail_block));

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rdat(input int b, input int i);
        return 8'(b * 37 + i * 11 + 5);
    endfunction

    // card model state
    int mode = 0, rblk = 0, rpos = 0, wph = 0, wcnt = 0, wblk = 0, lat = 0, nx = 0;
    int lead[8], bsy[8], stop_bsy = 0;
    logic [7:0] resp[8];
    logic [7:0] txlog[256];
    logic [7:0] exp_tx[256];
    int ne = 0;
    logic [7:0] held = 8'hFF, r = 8'hFF;

    // card: answer each requested byte two cycles later
    always @(negedge clk) begin
        spi_fin = 1'b0;
        if (lat > 0) begin
            lat--;
            if (lat == 0) begin spi_fin = 1'b1; spi_rx = held; end
        end
        if (spi_go) begin
            if (nx < 256) txlog[nx] = spi_tx;
            nx++;
            r = 8'hFF;
            if (mode == 0) begin
                if (rpos < lead[rblk])              r = (rpos % 2 == 1) ? 8'h7F : 8'hFF;
                else if (rpos == lead[rblk])        r = 8'hFE;
                else if (rpos <= lead[rblk] + B)    r = rdat(rblk, rpos - lead[rblk] - 1);
                else if (rpos == lead[rblk] + B + 1) r = 8'(8'hC0 + rblk);
                else                                r = 8'(8'h30 + rblk);
                if (rpos == lead[rblk] + B + 2) begin rblk++; rpos = 0; end
                else rpos++;
            end else begin
                case (wph)
                    0: begin
                        if (spi_tx == 8'hFE || spi_tx == 8'hFC) begin wph = 1; wcnt = 0; end
                        else if (spi_tx == 8'hFD) begin wph = 4; wcnt = 0; end
                    end
                    1: begin wcnt++; if (wcnt == B + 2) wph = 2; end
                    2: begin r = resp[wblk]; wph = 3; wcnt = 0; end
                    3: if (wcnt < bsy[wblk]) begin r = 8'h00; wcnt++; end
                       else begin wph = 0; wblk++; end
                    default: if (wcnt < stop_bsy) begin r = 8'h00; wcnt++; end
                             else wph = 0;
                endcase
            end
            held = r;
            lat  = 2;
        end
    end

    // streams: write source and read sink with stall patterns
    int cyc = 0, wr_idx = 0, rd_idx = 0, rd_bad = 0;
    bit wr_en = 0, rd_en = 0, wr_hs = 0;
    always @(negedge clk) begin
        cyc++;
        if (wr_hs) wr_idx++;
        wr_valid = wr_en && (cyc % 4 != 1);
        wr_data  = 8'(wr_idx * 29 + 3);
        wr_hs    = wr_valid && wr_ready;
        rd_ready = rd_en && (cyc % 3 != 0);
        if (rd_valid && rd_ready) begin
            if (rd_data != rdat(rd_idx / B, rd_idx % B)) rd_bad++;
            rd_idx++;
        end
    end

    task automatic push(input logic [7:0] v);
        exp_tx[ne] = v;
        ne++;
    endtask

    task automatic prep(input int m);
        mode = m; rblk = 0; rpos = 0; wph = 0; wcnt = 0; wblk = 0; nx = 0;
        rd_idx = 0; rd_bad = 0; wr_idx = 0; ne = 0;
        wr_en = (m == 1); rd_en = 1;
    endtask

    int got_st, got_fb, got_cyc;
    task automatic run(input bit wr, input int count, input bit poke, input string tag);
        @(negedge clk);
        write_mode = wr; block_count = CW'(count); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_cyc = 1;
        if (poke) begin
            repeat (8) @(negedge clk);
            got_cyc += 8;
            write_mode = ~wr; block_count = '0; start = 1'b1;  // R11 stray start
            @(negedge clk);
            start = 1'b0; write_mode = wr;
            got_cyc++;
        end
        while (!done && got_cyc < 3000) begin
            @(negedge clk);
            got_cyc++;
        end
        if (!done) check({tag, " R12 done never seen"}, 0, 1);
        check({tag, " R12 busy low with done"}, busy, 0);
        got_st = status; got_fb = fail_block;
        @(negedge clk);
        check({tag, " R12 done one cycle"}, done, 0);
        check({tag, " R12 status held"}, status, got_st);
        repeat (30) @(negedge clk);
    endtask

    task automatic check_log(input string tag);
        int bad = 0;
        check({tag, " byte count"}, nx, ne);
        for (int i = 0; i < ne && i < 256; i++) if (txlog[i] != exp_tx[i]) bad++;
        check({tag, " byte log mismatches"}, bad, 0);
    endtask

    task automatic read_case(input int count, input bit poke, input string tag);
        int est = 0, efb = 0, blocks = 0;
        prep(0);
        for (int b = 0; b < count; b++) begin
            if (lead[b] >= TP) begin
                for (int i = 0; i < TP; i++) push(8'hFF);
                est = 1; efb = b; break;
            end
            for (int i = 0; i < lead[b] + 1 + B + 2; i++) push(8'hFF);
            blocks++;
        end
        run(1'b0, count, poke, tag);
        check({tag, " status"}, got_st, est);
        if (est != 0) check({tag, " R4 fail_block"}, got_fb, efb);
        check_log(tag);
        check({tag, " R2 bytes delivered"}, rd_idx, blocks * B);
        check({tag, " R2 data mismatches"}, rd_bad, 0);
        if (blocks > 0)
            check({tag, " R3 crc_word"}, crc_word,
                  {8'(8'hC0 + blocks - 1), 8'(8'h30 + blocks - 1)});
    endtask

    task automatic write_case(input int count, input string tag);
        int est = 0, efb = 0, k = 0;
        bit to = 0;
        prep(1);
        for (int b = 0; b < count; b++) begin
            push(count > 1 ? 8'hFC : 8'hFE);
            for (int i = 0; i < B; i++) begin push(8'(k * 29 + 3)); k++; end
            push(8'hFF); push(8'hFF); push(8'hFF);
            if (bsy[b] >= BP) begin
                for (int i = 0; i < BP; i++) push(8'hFF);
                est = 3; efb = b; to = 1; break;
            end
            for (int i = 0; i < bsy[b] + 1; i++) push(8'hFF);
            if ((resp[b] & 8'h1F) != 8'h05) begin est = 2; efb = b; break; end
        end
        if (!to && count > 1) begin
            push(8'hFD);
            for (int i = 0; i < stop_bsy + 1; i++) push(8'hFF);
        end
        run(1'b1, count, 1'b0, tag);
        check({tag, " status"}, got_st, est);
        if (est != 0) check({tag, " fail_block"}, got_fb, efb);
        check_log(tag);
        check({tag, " stream bytes taken"}, wr_idx, k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin lead[i] = 0; bsy[i] = 0; resp[i] = 8'h05; end
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 spi_go", spi_go, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 wr_ready", wr_ready, 0);
        check("R1 status", status, 0);
        check("R1 crc_word", crc_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        lead[0] = 0;
        read_case(1, 1'b0, "R2 R3 single read");

        lead[0] = 1; lead[1] = TP - 1; lead[2] = 0;
        read_case(3, 1'b1, "R5 R11 multi read");

        lead[0] = 0; lead[1] = TP;
        read_case(2, 1'b0, "R4 token timeout");

        resp[0] = 8'hE5; bsy[0] = 2;
        write_case(1, "R6 R8 single write");

        resp[0] = 8'h05; resp[1] = 8'h05; resp[2] = 8'h05;
        bsy[0] = 0; bsy[1] = BP - 1; bsy[2] = 1; stop_bsy = 2;
        write_case(3, "R6 R9 multi write");

        resp[0] = 8'h05; resp[1] = 8'h0B; bsy[0] = 1; bsy[1] = 0; stop_bsy = 1;
        write_case(3, "R7 R9 multi reject");

        resp[0] = 8'hED; bsy[0] = 1;
        write_case(1, "R7 single reject");

        resp[0] = 8'h05; bsy[0] = BP;
        write_case(2, "R8 busy timeout");

        prep(0);
        run(1'b0, 0, 1'b0, "R10 zero count");
        check("R10 done latency", got_cyc, 1);
        check("R10 status", got_st, 0);
        check("R10 no transfers", nx, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule